// File: doc/BRIEF.md
# Conditional Instruction Class Decoder

This block sits at the front of a 32-bit execute stage. For each incoming instruction word it decides two things. The first is whether the instruction may run, which is set by the 4-bit condition field in bits 31:28 and the current flag vector {N, Z, C, V}. The second is the format class the word belongs to, which the execute logic uses to steer the word to the right unit.

The class comes from a 12-bit key. Key bits 11:4 are instruction bits 27:20, and key bits 3:0 are instruction bits 7:4. The key is tested against an ordered list of mask/pattern pairs, and the first pair that matches sets the class. A key that matches no pair gets an "unknown" code. A word with the reserved condition value raises an error flag and is never marked for execution.

All results are registered and appear one clock after the input strobe.

Top module: `cond_class_decode`

## Requirements
- R1: Every cycle with `inValid` high is followed, one clock later, by `outValid` high together with that word's `outExec`, `outClass` and `outResvErr`. A cycle with `inValid` low is followed by `outValid` low.
- R2: While `rstN` is low, all of `outValid`, `outExec`, `outResvErr` and `outClass` are 0.
- R3: `flags` is ordered {N, Z, C, V} in bits 3:0. The condition values 0x0 to 0x7 pass as follows: 0x0 on Z=1, 0x1 on Z=0, 0x2 on C=1, 0x3 on C=0, 0x4 on N=1, 0x5 on N=0, 0x6 on V=1, 0x7 on V=0.
- R4: Condition 0x8 passes when C=1 and Z=0. Condition 0x9 passes when C=0 or Z=1.
- R5: Condition 0xA passes when N equals V, and 0xB passes when they differ. Condition 0xC passes when Z=0 and N equals V. Condition 0xD passes when Z=1 or N differs from V.
- R6: Condition 0xE always passes. Condition 0xF sets `outResvErr`=1 and `outExec`=0, and `outResvErr` is 0 for every other condition value.
- R7: The first matching rule sets the class code. The rules are checked in this order: 0 trap (key&0xF00==0xF00), 1 coprocessor register/operation (key&0xF01==0xE01), 2 coprocessor transfer (key&0xE00==0xC00), 3 branch (key&0xE00==0xA00), 4 block transfer (key&0xE00==0x800), 5 undefined (key&0xE01==0x601), 6 single transfer (key&0xC00==0x400).
- R8: The rules continue in this order: 7 halfword immediate (key&0xE49==0x049), 8 halfword register (key&0xE49==0x009), 9 branch-exchange (key==0x121), 10 swap (key&0xFBF==0x109), 11 long multiply (key&0xF8F==0x089), 12 multiply (key&0xFCF==0x009), 13 data processing (key&0xC00==0x000). Because the order is strict, a key such as 0x109 takes code 8.
- R9: A key that matches no rule, for example 0xE00, gives class code 14.
- R10: When the condition fails, `outValid` is still 1 and `outExec` is 0.
- R11: When `inValid` is low, `outExec`, `outClass` and `outResvErr` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Instruction and flags are valid this cycle |
| instr | input | 32 | Instruction word |
| flags | input | 4 | Condition flags {N, Z, C, V} |
| outValid | output | 1 | Registered result valid |
| outExec | output | 1 | Condition passed and is not reserved |
| outClass | output | 4 | Class code, 0 to 14 |
| outResvErr | output | 1 | Reserved condition seen |

## Verification
Every result is due exactly one clock after the edge that captures the input. The bench drives each vector on a falling edge and reads the outputs on the next falling edge, which comes after the single capturing rising edge and before any new input is applied. The hold case follows the same pattern: one idle cycle with a changed instruction, then a read on the following falling edge. Reset values are read while reset is held low, without waiting for a clock.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

  localparam int INSTR_W    = 32;
  localparam int FLAG_W     = 4;
  localparam int KEY_W      = 12;
  localparam int CLASS_W    = 4;
  localparam int RULE_COUNT = 14;

  typedef enum logic [CLASS_W-1:0] {
    CLS_TRAP      = 4'd0,
    CLS_CP_REG    = 4'd1,
    CLS_CP_XFER   = 4'd2,
    CLS_BRANCH    = 4'd3,
    CLS_BLOCK     = 4'd4,
    CLS_UNDEF     = 4'd5,
    CLS_SINGLE    = 4'd6,
    CLS_HALF_IMM  = 4'd7,
    CLS_HALF_REG  = 4'd8,
    CLS_BR_XCHG   = 4'd9,
    CLS_SWAP      = 4'd10,
    CLS_MUL_LONG  = 4'd11,
    CLS_MUL       = 4'd12,
    CLS_DATA_PROC = 4'd13,
    CLS_UNKNOWN   = 4'd14
  } instr_class_e;

  typedef struct packed {
    logic load;
    logic exec;
    logic resvErr;
  } ctrl_strobe_t;

  localparam logic [KEY_W-1:0] RULE_MASK [RULE_COUNT] = '{
    12'hF00, 12'hF01, 12'hE00, 12'hE00, 12'hE00, 12'hE01, 12'hC00,
    12'hE49, 12'hE49, 12'hFFF, 12'hFBF, 12'hF8F, 12'hFCF, 12'hC00
  };

  localparam logic [KEY_W-1:0] RULE_PAT [RULE_COUNT] = '{
    12'hF00, 12'hE01, 12'hC00, 12'hA00, 12'h800, 12'h601, 12'h400,
    12'h049, 12'h009, 12'h121, 12'h109, 12'h089, 12'h009, 12'h000
  };

endpackage

// File: rtl/ccd_ctrl.sv
module ccd_ctrl
  import ccd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [3:0]        cond,
  input  logic [FLAG_W-1:0] flags,
  output ctrl_strobe_t      strobe
);

  logic flagN, flagZ, flagC, flagV;
  logic condPass;
  logic isReserved;

  assign flagN = flags[3];
  assign flagZ = flags[2];
  assign flagC = flags[1];
  assign flagV = flags[0];

  always_comb begin
    condPass   = 1'b0;
    isReserved = 1'b0;
    unique case (cond)
      4'h0: condPass = flagZ;
      4'h1: condPass = !flagZ;
      4'h2: condPass = flagC;
      4'h3: condPass = !flagC;
      4'h4: condPass = flagN;
      4'h5: condPass = !flagN;
      4'h6: condPass = flagV;
      4'h7: condPass = !flagV;
      4'h8: condPass = flagC && !flagZ;
      4'h9: condPass = !flagC || flagZ;
      4'hA: condPass = (flagN == flagV);
      4'hB: condPass = (flagN != flagV);
      4'hC: condPass = !flagZ && (flagN == flagV);
      4'hD: condPass = flagZ || (flagN != flagV);
      4'hE: condPass = 1'b1;
      4'hF: isReserved = 1'b1;
      default: condPass = 1'b0;
    endcase
  end

  assign strobe.load    = inValid;
  assign strobe.exec    = condPass && !isReserved;
  assign strobe.resvErr = isReserved;

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.resvErr |-> !strobe.exec);

endmodule

// File: rtl/ccd_datapath.sv
module ccd_datapath
  import ccd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instr,
  input  ctrl_strobe_t       strobe,
  output logic               outValid,
  output logic               outExec,
  output logic [CLASS_W-1:0] outClass,
  output logic               outResvErr
);

  logic [KEY_W-1:0]      key;
  logic [RULE_COUNT-1:0] ruleHit;
  instr_class_e          pickClass;

  assign key = {instr[27:20], instr[7:4]};

  for (genvar g = 0; g < RULE_COUNT; g++) begin : gen_rule
    assign ruleHit[g] = ((key & RULE_MASK[g]) == RULE_PAT[g]);
  end

  always_comb begin
    pickClass = CLS_UNKNOWN;
    for (int i = RULE_COUNT - 1; i >= 0; i--) begin
      if (ruleHit[i]) pickClass = instr_class_e'(CLASS_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outExec    <= 1'b0;
      outClass   <= '0;
      outResvErr <= 1'b0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        outExec    <= strobe.exec;
        outClass   <= pickClass;
        outResvErr <= strobe.resvErr;
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> outValid);

  // R1
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> !outValid);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(outClass) && $stable(outExec) && $stable(outResvErr)));

  // R6
  resv_no_exec_chk: assert property (@(posedge clk) disable iff (!rstN)
    outResvErr |-> !outExec);

  // R9
  class_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outClass <= 4'd14));

endmodule

// File: rtl/cond_class_decode.sv
module cond_class_decode
  import ccd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [FLAG_W-1:0]  flags,
  output logic               outValid,
  output logic               outExec,
  output logic [CLASS_W-1:0] outClass,
  output logic               outResvErr
);

  ctrl_strobe_t strobe;

  ccd_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .cond    (instr[31:28]),
    .flags   (flags),
    .strobe  (strobe)
  );

  ccd_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .instr      (instr),
    .strobe     (strobe),
    .outValid   (outValid),
    .outExec    (outExec),
    .outClass   (outClass),
    .outResvErr (outResvErr)
  );

endmodule

// File: tb/sim_cond_class_decode.sv
module sim_cond_class_decode;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instr = '0;
  logic [3:0]  flags = '0;
  logic        outValid, outExec, outResvErr;
  logic [3:0]  outClass;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cond_class_decode u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr), .flags(flags),
    .outValid(outValid), .outExec(outExec), .outClass(outClass),
    .outResvErr(outResvErr)
  );

  // {req, instr, flags, expExec, expErr, expClass}
  localparam int NV = 41;
  localparam logic [45:0] VEC [NV] = '{
    // R7 class priority, first half
    {4'd7, 32'hEF000000, 4'h0, 1'b1, 1'b0, 4'd0},
    {4'd7, 32'hEE000010, 4'h0, 1'b1, 1'b0, 4'd1},
    {4'd7, 32'hEC000000, 4'h0, 1'b1, 1'b0, 4'd2},
    {4'd7, 32'hEA000000, 4'h0, 1'b1, 1'b0, 4'd3},
    {4'd7, 32'hE8000000, 4'h0, 1'b1, 1'b0, 4'd4},
    {4'd7, 32'hE6000010, 4'h0, 1'b1, 1'b0, 4'd5},
    {4'd7, 32'hE6000000, 4'h0, 1'b1, 1'b0, 4'd6},
    {4'd7, 32'hE4000000, 4'h0, 1'b1, 1'b0, 4'd6},
    // R8 second half and shadowing
    {4'd8, 32'hE04000B0, 4'h0, 1'b1, 1'b0, 4'd7},
    {4'd8, 32'hE00000B0, 4'h0, 1'b1, 1'b0, 4'd8},
    {4'd8, 32'hE12FFF10, 4'h0, 1'b1, 1'b0, 4'd9},
    {4'd8, 32'hE1000090, 4'h0, 1'b1, 1'b0, 4'd8},
    {4'd8, 32'hE0800010, 4'h0, 1'b1, 1'b0, 4'd13},
    {4'd8, 32'hE3A00001, 4'h0, 1'b1, 1'b0, 4'd13},
    // R9 no rule matches
    {4'd9, 32'hEE000000, 4'h0, 1'b1, 1'b0, 4'd14},
    // R3 simple flag tests
    {4'd3, 32'h00000000, 4'h4, 1'b1, 1'b0, 4'd13},
    {4'd3, 32'h00000000, 4'h0, 1'b0, 1'b0, 4'd13},
    {4'd3, 32'h10000000, 4'h0, 1'b1, 1'b0, 4'd13},
    {4'd3, 32'h20000000, 4'h2, 1'b1, 1'b0, 4'd13},
    {4'd3, 32'h30000000, 4'h2, 1'b0, 1'b0, 4'd13},
    {4'd3, 32'h40000000, 4'h8, 1'b1, 1'b0, 4'd13},
    {4'd3, 32'h50000000, 4'h8, 1'b0, 1'b0, 4'd13},
    {4'd3, 32'h60000000, 4'h1, 1'b1, 1'b0, 4'd13},
    {4'd3, 32'h70000000, 4'h0, 1'b1, 1'b0, 4'd13},
    {4'd3, 32'h70000000, 4'h1, 1'b0, 1'b0, 4'd13},
    // R4 carry/zero combinations
    {4'd4, 32'h80000000, 4'h2, 1'b1, 1'b0, 4'd13},
    {4'd4, 32'h80000000, 4'h6, 1'b0, 1'b0, 4'd13},
    {4'd4, 32'h90000000, 4'h6, 1'b1, 1'b0, 4'd13},
    {4'd4, 32'h90000000, 4'h2, 1'b0, 1'b0, 4'd13},
    // R5 sign/overflow combinations
    {4'd5, 32'hA0000000, 4'h9, 1'b1, 1'b0, 4'd13},
    {4'd5, 32'hA0000000, 4'h8, 1'b0, 1'b0, 4'd13},
    {4'd5, 32'hB0000000, 4'h8, 1'b1, 1'b0, 4'd13},
    {4'd5, 32'hB0000000, 4'h9, 1'b0, 1'b0, 4'd13},
    {4'd5, 32'hC0000000, 4'h0, 1'b1, 1'b0, 4'd13},
    {4'd5, 32'hC0000000, 4'h1, 1'b0, 1'b0, 4'd13},
    {4'd5, 32'hD0000000, 4'h4, 1'b1, 1'b0, 4'd13},
    {4'd5, 32'hD0000000, 4'h0, 1'b0, 1'b0, 4'd13},
    // R6 always and reserved
    {4'd6, 32'hE0000000, 4'hF, 1'b1, 1'b0, 4'd13},
    {4'd6, 32'hF0000000, 4'h0, 1'b0, 1'b1, 4'd13},
    {4'd6, 32'hFF000000, 4'hF, 1'b0, 1'b1, 4'd0},
    // R10 failed condition still valid
    {4'd10, 32'h0A000000, 4'h0, 1'b0, 1'b0, 4'd3}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] holdClass;
    logic       holdExec;
    // R2 reset state
    repeat (3) @(negedge clk);
    check("R2 valid", 32'(outValid), 0);
    check("R2 exec", 32'(outExec), 0);
    check("R2 class", 32'(outClass), 0);
    check("R2 err", 32'(outResvErr), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 32'(outValid), 0);

    // vector table: R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      string tag;
      instr   = VEC[i][41:10];
      flags   = VEC[i][9:6];
      inValid = 1'b1;
      @(negedge clk);
      tag = $sformatf("R%0d vec%0d", VEC[i][45:42], i);
      check({tag, " valid (R1)"}, 32'(outValid), 1);
      check({tag, " exec"}, 32'(outExec), 32'(VEC[i][5]));
      check({tag, " err"}, 32'(outResvErr), 32'(VEC[i][4]));
      check({tag, " class"}, 32'(outClass), 32'(VEC[i][3:0]));
    end

    // R11 hold while idle; R1 valid drops
    holdClass = outClass;
    holdExec  = outExec;
    inValid = 1'b0;
    instr   = 32'hEF000000;
    flags   = 4'hF;
    @(negedge clk);
    check("R1 idle valid", 32'(outValid), 0);
    check("R11 class hold", 32'(outClass), 32'(holdClass));
    check("R11 exec hold", 32'(outExec), 32'(holdExec));
    check("R11 err hold", 32'(outResvErr), 0);

    // R6 reserved followed by a normal word clears the error
    inValid = 1'b1;
    instr = 32'hF0000000;
    @(negedge clk);
    check("R6 err set", 32'(outResvErr), 1);
    instr = 32'hE0000000;
    @(negedge clk);
    check("R6 err cleared", 32'(outResvErr), 0);
    check("R6 exec", 32'(outExec), 1);

    // R2 asynchronous reset mid-run
    instr = 32'hEA000000;
    @(negedge clk);
    #3 rstN = 1'b0;
    #2;
    check("R2 mid valid", 32'(outValid), 0);
    check("R2 mid class", 32'(outClass), 0);
    check("R2 mid exec", 32'(outExec), 0);
    inValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule